// File: doc/BRIEF.md
# Dual-Rail OR/AND Block with Selectable Early Firing

This block computes two functions of three logical inputs carried on dual-rail wires: `z` is the OR of the three inputs and `w` is their AND. Every logical signal uses a pair of wires. Bit 1 is the one-rail and bit 0 is the zero-rail. The codes are: 00 for the empty spacer (NULL), 01 for logic 0 and 10 for logic 1. The code 11 is illegal. The surrounding pipeline runs four-phase cycles. All inputs go from NULL to DATA, and then all return to NULL before the next token.

The logic is made of C-elements followed by OR gates. Each C-element is modelled as a state element clocked by `clk`. Its output rises once all of its inputs are high, falls once all of its inputs are low, and otherwise holds. Every output therefore reflects the input state that was sampled at the previous clock edge. A compile-time parameter picks one of four constructions:

- Complete: both outputs wait for all three inputs.
- Biased: `z` waits for all inputs, while `w` reports 0 early.
- Distributive: `z` watches `a` and `b`, `w` watches `b` and `c`, and `c` or `a` is added only where needed. Between them the two outputs still see every input arrive.
- Eager: both outputs fire as soon as the dominating value shows up.

An error flag marks any input pair that carries the illegal code.

Top module: `drl_orand_block`

## Requirements
- R1: While `rst_n` is low, both outputs read 00 (NULL) and `code_err` reads 0. A change at the inputs shows at the outputs one clock edge later.
- R2: Whenever an output carries DATA, its value is the OR (for `z`) or the AND (for `w`) of the decoded inputs: 10 means 1 and 01 means 0.
- R3: Complete style: each output leaves NULL only after all three inputs carry DATA.
- R4: Biased style: `z` waits for all three inputs. `w` goes to 01 once any arrived input is 0, and goes to 10 only when all three inputs are 1.
- R5: Distributive style: `z` waits for `a` and `b`, plus `c` when both are 0. `w` waits for `b` and `c`, plus `a` when both are 1.
- R6: Eager style: `z` goes to 10 once any arrived input is 1, and to 01 only when all three are 0. `w` goes to 01 once any arrived input is 0, and to 10 only when all three are 1.
- R7: In the NULL phase, an output keeps its DATA value until every input it waited on has returned to 00. For an early-firing result, that means every input that carried the deciding value.
- R8: Neither output ever shows the code 11.
- R9: `code_err` is 1 one edge after any input pair reads 11, and 0 one edge after none does.
- R10: In the complete, biased and distributive styles, the first cycle in which both outputs carry DATA follows an edge at which all three inputs carried DATA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the C-element model |
| rst_n | input | 1 | Asynchronous active-low reset, clears every C-element |
| a_dr | input | 2 | Input `a`, {one-rail, zero-rail} |
| b_dr | input | 2 | Input `b`, {one-rail, zero-rail} |
| c_dr | input | 2 | Input `c`, {one-rail, zero-rail} |
| z_dr | output | 2 | OR result, dual-rail |
| w_dr | output | 2 | AND result, dual-rail |
| code_err | output | 1 | Registered flag: some input carried 11 |

## Verification
The arrival, value and joint-completeness properties assume a proper four-phase environment. In it, an input only moves from NULL to a legal DATA code and back, no input returns to NULL before the DATA phase is finished, and all inputs reach NULL before the next token starts. The stimulus follows that discipline for all eight input vectors and every order of arrival and departure. It breaks the discipline only once, with a single 11 code on `a` taken from and returned to an all-NULL state, so that only the error flag and the output legality are judged there. The reset check in the middle of a token takes place with the properties disabled by reset.

// File: rtl/drl_pkg.sv
package drl_pkg;
  localparam int N_IN  = 3;
  localparam int RAILS = 2;
  localparam int N_MT  = 1 << N_IN;

  typedef enum logic [1:0] {
    STY_COMPLETE = 2'd0,
    STY_BIASED   = 2'd1,
    STY_DISTRIB  = 2'd2,
    STY_EAGER    = 2'd3
  } drl_style_e;

  localparam logic [RAILS-1:0] DR_NULL = 2'b00;
  localparam logic [RAILS-1:0] DR_ZERO = 2'b01;
  localparam logic [RAILS-1:0] DR_ONE  = 2'b10;
endpackage

// File: rtl/drl_celem.sv
module drl_celem #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] ins,
  output logic             q
);
  logic q_nxt;

  // rise on all-high, fall on all-low, otherwise keep state
  always_comb begin
    q_nxt = q;
    if (&ins)       q_nxt = 1'b1;
    else if (~|ins) q_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/drl_minterm_bank.sv
module drl_minterm_bank
  import drl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RAILS-1:0] a_dr,
  input  logic [RAILS-1:0] b_dr,
  input  logic [RAILS-1:0] c_dr,
  output logic [N_MT-1:0]  hit
);
  // minterm index m = {c,b,a}; rail index equals the logical value
  for (genvar m = 0; m < N_MT; m++) begin : g_mt
    localparam logic [N_IN-1:0] MV = N_IN'(m);
    drl_celem #(.WIDTH(N_IN)) u_c (
      .clk  (clk),
      .rst_n(rst_n),
      .ins  ({c_dr[MV[2]], b_dr[MV[1]], a_dr[MV[0]]}),
      .q    (hit[m])
    );
  end
endmodule

// File: rtl/drl_style_net.sv
module drl_style_net
  import drl_pkg::*;
#(
  parameter drl_style_e STYLE = STY_COMPLETE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RAILS-1:0] a_dr,
  input  logic [RAILS-1:0] b_dr,
  input  logic [RAILS-1:0] c_dr,
  output logic [RAILS-1:0] z_dr,
  output logic [RAILS-1:0] w_dr
);
  localparam bit USE_BANK = (STYLE == STY_COMPLETE) || (STYLE == STY_BIASED);

  logic [N_IN-1:0] rail1;
  logic [N_IN-1:0] rail0;
  assign rail1 = {c_dr[1], b_dr[1], a_dr[1]};
  assign rail0 = {c_dr[0], b_dr[0], a_dr[0]};

  if (USE_BANK) begin : g_full
    logic [N_MT-1:0] hit;
    drl_minterm_bank u_bank (
      .clk(clk), .rst_n(rst_n), .a_dr(a_dr), .b_dr(b_dr), .c_dr(c_dr), .hit(hit)
    );
    assign z_dr = {|hit[N_MT-1:1], hit[0]};

    if (STYLE == STY_COMPLETE) begin : g_wfull
      assign w_dr = {hit[N_MT-1], |hit[N_MT-2:0]};
    end else begin : g_wbias
      logic [N_IN-1:0] zero_seen;
      for (genvar i = 0; i < N_IN; i++) begin : g_z
        drl_celem #(.WIDTH(1)) u_c (
          .clk(clk), .rst_n(rst_n), .ins(rail0[i]), .q(zero_seen[i])
        );
      end
      assign w_dr = {hit[N_MT-1], |zero_seen};
    end
  end else if (STYLE == STY_DISTRIB) begin : g_dist
    logic [2:0] z_pair;
    logic [2:0] w_pair;
    logic       z_ab0_c1, z_all0, w_a0_bc1, w_all1;

    for (genvar t = 0; t < 3; t++) begin : g_pair
      localparam logic [1:0] ZV = 2'(t + 1);
      localparam logic [1:0] WV = 2'(t);
      drl_celem #(.WIDTH(2)) u_zp (
        .clk(clk), .rst_n(rst_n), .ins({b_dr[ZV[1]], a_dr[ZV[0]]}), .q(z_pair[t])
      );
      drl_celem #(.WIDTH(2)) u_wp (
        .clk(clk), .rst_n(rst_n), .ins({c_dr[WV[1]], b_dr[WV[0]]}), .q(w_pair[t])
      );
    end

    drl_celem #(.WIDTH(3)) u_zc (
      .clk(clk), .rst_n(rst_n), .ins({c_dr[1], b_dr[0], a_dr[0]}), .q(z_ab0_c1)
    );
    drl_celem #(.WIDTH(3)) u_z0 (
      .clk(clk), .rst_n(rst_n), .ins(rail0), .q(z_all0)
    );
    drl_celem #(.WIDTH(3)) u_wa (
      .clk(clk), .rst_n(rst_n), .ins({c_dr[1], b_dr[1], a_dr[0]}), .q(w_a0_bc1)
    );
    drl_celem #(.WIDTH(3)) u_w1 (
      .clk(clk), .rst_n(rst_n), .ins(rail1), .q(w_all1)
    );

    assign z_dr = {(|z_pair) | z_ab0_c1, z_all0};
    assign w_dr = {w_all1, (|w_pair) | w_a0_bc1};
  end else begin : g_eager
    logic [N_IN-1:0] one_seen;
    logic [N_IN-1:0] zero_seen;
    logic            all0, all1;

    for (genvar i = 0; i < N_IN; i++) begin : g_rail
      drl_celem #(.WIDTH(1)) u_o (
        .clk(clk), .rst_n(rst_n), .ins(rail1[i]), .q(one_seen[i])
      );
      drl_celem #(.WIDTH(1)) u_z (
        .clk(clk), .rst_n(rst_n), .ins(rail0[i]), .q(zero_seen[i])
      );
    end
    drl_celem #(.WIDTH(N_IN)) u_a0 (
      .clk(clk), .rst_n(rst_n), .ins(rail0), .q(all0)
    );
    drl_celem #(.WIDTH(N_IN)) u_a1 (
      .clk(clk), .rst_n(rst_n), .ins(rail1), .q(all1)
    );

    assign z_dr = {|one_seen, all0};
    assign w_dr = {all1, |zero_seen};
  end
endmodule

// File: rtl/drl_orand_block.sv
module drl_orand_block
  import drl_pkg::*;
#(
  parameter drl_style_e STYLE = STY_COMPLETE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] a_dr,
  input  logic [1:0] b_dr,
  input  logic [1:0] c_dr,
  output logic [1:0] z_dr,
  output logic [1:0] w_dr,
  output logic       code_err
);
  logic err_nxt;

  drl_style_net #(.STYLE(STYLE)) u_net (
    .clk  (clk),
    .rst_n(rst_n),
    .a_dr (a_dr),
    .b_dr (b_dr),
    .c_dr (c_dr),
    .z_dr (z_dr),
    .w_dr (w_dr)
  );

  always_comb begin
    err_nxt = (&a_dr) | (&b_dr) | (&c_dr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_err <= 1'b0;
    else        code_err <= err_nxt;
  end
endmodule

// File: rtl/drl_orand_chk.sv
module drl_orand_chk
  import drl_pkg::*;
#(
  parameter drl_style_e STYLE = STY_COMPLETE
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] a_dr,
  input logic [1:0] b_dr,
  input logic [1:0] c_dr,
  input logic [1:0] z_dr,
  input logic [1:0] w_dr,
  input logic       code_err
);
  logic [2:0] here;
  logic [2:0] legal;
  logic [2:0] val;
  logic       any_bad, zd, wd, armed;

  assign here    = {c_dr != 2'b00, b_dr != 2'b00, a_dr != 2'b00};
  assign legal   = {c_dr == DR_ZERO || c_dr == DR_ONE,
                    b_dr == DR_ZERO || b_dr == DR_ONE,
                    a_dr == DR_ZERO || a_dr == DR_ONE};
  assign val     = {c_dr == DR_ONE, b_dr == DR_ONE, a_dr == DR_ONE};
  assign any_bad = (a_dr == 2'b11) || (b_dr == 2'b11) || (c_dr == 2'b11);
  assign zd      = z_dr != 2'b00;
  assign wd      = w_dr != 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_z_legal_R8: assert property (@(posedge clk) disable iff (!rst_n) z_dr != 2'b11);
  assert_w_legal_R8: assert property (@(posedge clk) disable iff (!rst_n) w_dr != 2'b11);

  assert_z_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (zd && $past(&legal)) |-> (z_dr == ($past(|val) ? DR_ONE : DR_ZERO)));
  assert_w_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wd && $past(&legal)) |-> (w_dr == ($past(&val) ? DR_ONE : DR_ZERO)));

  assert_err_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (code_err == $past(any_bad)));

  if (STYLE == STY_COMPLETE) begin : g_c
    assert_z_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (zd && !$past(zd)) |-> $past(&here));
    assert_w_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wd && !$past(wd)) |-> $past(&here));
    assert_z_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!zd && $past(zd)) |-> $past(here == 3'b000));
  end else if (STYLE == STY_BIASED) begin : g_b
    assert_z_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (zd && !$past(zd)) |-> $past(&here));
    assert_w_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (w_dr == DR_ONE && $past(w_dr) != DR_ONE) |-> $past(&here));
  end else if (STYLE == STY_DISTRIB) begin : g_d
    assert_z_ab_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (zd && !$past(zd)) |-> $past(here[0] && here[1]));
    assert_w_bc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wd && !$past(wd)) |-> $past(here[1] && here[2]));
  end else begin : g_e
    assert_z_some_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (zd && !$past(zd)) |-> $past(|here));
    assert_w_some_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wd && !$past(wd)) |-> $past(|here));
  end

  if (STYLE != STY_EAGER) begin : g_joint
    assert_joint_complete_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (zd && wd && !($past(zd) && $past(wd))) |-> $past(&here));
  end
endmodule

bind drl_orand_block drl_orand_chk #(.STYLE(STYLE)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .a_dr    (a_dr),
  .b_dr    (b_dr),
  .c_dr    (c_dr),
  .z_dr    (z_dr),
  .w_dr    (w_dr),
  .code_err(code_err)
);

// File: tb/drl_orand_block_tb.sv
module drl_orand_block_tb;
  import drl_pkg::*;

  localparam int NSTY = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] a_dr, b_dr, c_dr;
  logic [1:0] z_dr [NSTY];
  logic [1:0] w_dr [NSTY];
  logic       err_v [NSTY];

  always #10 clk = ~clk;

  for (genvar s = 0; s < NSTY; s++) begin : g_sty
    drl_orand_block #(.STYLE(drl_style_e'(s))) u_dut (
      .clk(clk), .rst_n(rst_n), .a_dr(a_dr), .b_dr(b_dr), .c_dr(c_dr),
      .z_dr(z_dr[s]), .w_dr(w_dr[s]), .code_err(err_v[s])
    );
  end

  typedef struct packed {
    logic [7:0] zx;
    logic [7:0] wx;
    logic       ex;
    logic       outs;
    logic [3:0] rq;
  } exp_t;

  exp_t sbq[$];
  int   n_chk  = 0;
  int   n_fail = 0;

  function automatic string rname(int r);
    case (r)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   default: return "R10";
    endcase
  endfunction

  task automatic check(bit ok, int r, string what, logic [1:0] act, logic [1:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", rname(r), what, act, expv);
    end
  endtask

  // {any-of, mask}; bit0=a, bit1=b, bit2=c
  function automatic logic [3:0] rule(int s, bit is_w, logic [2:0] v);
    case (s)
      0: return {1'b0, 3'b111};
      1: if (!is_w || v == 3'b111) return {1'b0, 3'b111};
         else return {1'b1, ~v};
      2: if (!is_w) return (v[0] | v[1]) ? {1'b0, 3'b011} : {1'b0, 3'b111};
         else return (v[1] & v[2]) ? {1'b0, 3'b111} : {1'b0, 3'b110};
      default:
         if (!is_w) return (v != 3'b000) ? {1'b1, v} : {1'b0, 3'b111};
         else return (v != 3'b111) ? {1'b1, ~v} : {1'b0, 3'b111};
    endcase
  endfunction

  function automatic logic [1:0] exp_out(int s, bit is_w, logic [2:0] v,
                                         logic [2:0] pres, bit nullph);
    logic [3:0] r;
    bit fired, value;
    r = rule(s, is_w, v);
    if (nullph || r[3]) fired = |(r[2:0] & pres);
    else                fired = ((r[2:0] & pres) == r[2:0]);
    value = is_w ? &v : |v;
    return fired ? (value ? 2'b10 : 2'b01) : 2'b00;
  endfunction

  function automatic int perm(int p, int k);
    case (p)
      0: return k;
      1: return (k == 0) ? 0 : 3 - k;
      2: return (k == 0) ? 1 : (k == 1) ? 0 : 2;
      3: return (k == 0) ? 1 : (k == 1) ? 2 : 0;
      4: return (k == 0) ? 2 : (k == 1) ? 0 : 1;
      default: return 2 - k;
    endcase
  endfunction

  task automatic drive(logic [1:0] a, logic [1:0] b, logic [1:0] c, exp_t e);
    @(negedge clk);
    a_dr = a; b_dr = b; c_dr = c;
    sbq.push_back(e);
  endtask

  task automatic step(logic [2:0] v, logic [2:0] pres, bit nullph);
    exp_t e;
    e.ex = 1'b0;
    e.outs = 1'b1;
    for (int s = 0; s < NSTY; s++) begin
      e.zx[2*s +: 2] = exp_out(s, 1'b0, v, pres, nullph);
      e.wx[2*s +: 2] = exp_out(s, 1'b1, v, pres, nullph);
    end
    // tag: R7 on departures, R2 once everything arrived, style rule otherwise
    e.rq = nullph ? 4'd7 : (pres == 3'b111) ? 4'd2 : 4'd0;
    drive(pres[0] ? (v[0] ? 2'b10 : 2'b01) : 2'b00,
          pres[1] ? (v[1] ? 2'b10 : 2'b01) : 2'b00,
          pres[2] ? (v[2] ? 2'b10 : 2'b01) : 2'b00, e);
  endtask

  // monitor: compares each popped item 2 ns after the edge that registers it
  initial begin
    exp_t e;
    int   rq;
    forever begin
      @(posedge clk);
      #2;
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        for (int s = 0; s < NSTY; s++) begin
          rq = (e.rq == 4'd0) ? 3 + s : int'(e.rq);
          if (e.outs) begin
            check(z_dr[s] == e.zx[2*s +: 2], rq, $sformatf("style%0d z", s), z_dr[s], e.zx[2*s +: 2]);
            check(w_dr[s] == e.wx[2*s +: 2], rq, $sformatf("style%0d w", s), w_dr[s], e.wx[2*s +: 2]);
            check(z_dr[s] != 2'b11 && w_dr[s] != 2'b11, 8, $sformatf("style%0d legal", s),
                  z_dr[s] & w_dr[s], 2'b00);
          end
          check(err_v[s] == e.ex, (e.ex || e.rq == 4'd9) ? 9 : 1,
                $sformatf("style%0d err", s), {1'b0, err_v[s]}, {1'b0, e.ex});
        end
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    exp_t e;
    logic [2:0] pres;
    rst_n = 1'b0;
    a_dr = 2'b00; b_dr = 2'b00; c_dr = 2'b00;
    repeat (3) @(negedge clk);
    for (int s = 0; s < NSTY; s++) begin   // R1 reset state
      check(z_dr[s] == 2'b00, 1, "reset z", z_dr[s], 2'b00);
      check(w_dr[s] == 2'b00, 1, "reset w", w_dr[s], 2'b00);
      check(err_v[s] == 1'b0, 1, "reset err", {1'b0, err_v[s]}, 2'b00);
    end
    rst_n = 1'b1;

    for (int v = 0; v < 8; v++) begin
      for (int p = 0; p < 6; p++) begin
        for (int q = 0; q < 6; q++) begin
          pres = 3'b000;
          for (int k = 0; k < 3; k++) begin
            pres[perm(p, k)] = 1'b1;
            step(3'(v), pres, 1'b0);
          end
          for (int k = 0; k < 3; k++) begin
            pres[perm(q, k)] = 1'b0;
            step(3'(v), pres, 1'b1);
          end
        end
      end
    end

    // R9: illegal 11 on a, others NULL; eager terms react to its rails
    e.ex = 1'b1; e.outs = 1'b1; e.rq = 4'd9;
    e.zx = {2'b10, 2'b00, 2'b00, 2'b00};
    e.wx = {2'b01, 2'b00, 2'b01, 2'b00};
    drive(2'b11, 2'b00, 2'b00, e);
    e.ex = 1'b0; e.zx = 8'h00; e.wx = 8'h00;
    drive(2'b00, 2'b00, 2'b00, e);

    // R1: asynchronous reset in the middle of a DATA phase
    e.ex = 1'b0; e.outs = 1'b1; e.rq = 4'd2;
    e.zx = {4{2'b10}}; e.wx = {4{2'b10}};
    drive(2'b10, 2'b10, 2'b10, e);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #2;
    for (int s = 0; s < NSTY; s++) begin
      check(z_dr[s] == 2'b00, 1, "async reset z", z_dr[s], 2'b00);
      check(w_dr[s] == 2'b00, 1, "async reset w", w_dr[s], 2'b00);
    end
    a_dr = 2'b00; b_dr = 2'b00; c_dr = 2'b00;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    summary();
  end
endmodule